// File: doc/BRIEF.md
# Vector Register Load Sequencer

This block executes one instruction: an unpredicated load that fills a whole vector register from memory. It takes a 32-bit instruction word and the current vector length, and checks the word's fixed opcode bits and the vector length. It takes the scalar base from a general-purpose register read port, or from the stack pointer when the base index is 31. It adds an offset of the signed 9-bit immediate times the vector length in bytes to get the effective address.

After an alignment screen on the base, it reads memory one byte at a time over a request/ready channel with a separate response channel. It keeps one read outstanding and counts upward from the effective address. The returned bytes are placed into a vector-wide register, lowest byte first. When the last byte arrives, the whole value is written to the vector register file in a single cycle.

A memory error on any byte ends the sequence with a fault that reports the address, and no register is written. The block is used by an issue stage that presents a word when `busy` is low and waits for `busy` to fall.

Top module: `vload_seq`

## Requirements
- R1: An accepted word with bits [31:22] not equal to 1000010110 or bits [15:13] not equal to 010 pulses `undef` high for exactly one cycle. It leaves `busy` low and makes no memory request or register write.
- R2: A decodable word whose vector length is zero, not a multiple of 128, or above VLEN_MAX pulses `cfg_err` for one cycle and causes no other activity.
- R3: The immediate is the signed 9-bit value {word[21:16], word[12:10]}. The effective address is base + immediate × (vector length / 8), modulo 2^64.
- R4: The base index is word[9:5] and is driven on `rf_rd_idx`. Index 31 selects `sp_value` as the base instead of `rf_rd_data`.
- R5: With base index 31, `sp_chk_en` high and `sp_value[3:0]` nonzero, the block pulses `fault_valid` with `fault_kind` = 1 and `fault_addr` = `sp_value`, and issues no memory request.
- R6: With `align_en` high and base[3:0] nonzero, the block pulses `fault_valid` with `fault_kind` = 2 and `fault_addr` = effective address, and issues no request. With `align_en` low, a misaligned base loads normally.
- R7: A load issues exactly (vector length / 8) byte requests at consecutive ascending addresses from the effective address. It has one outstanding at a time, and each holds `mem_req` and `mem_addr` until `mem_ready`.
- R8: Byte e of the load lands in `vrf_data[8e+7:8e]`, and bits above the vector length are zero. `vrf_we` pulses once with `vrf_idx` = word[4:0], in the cycle after the last response.
- R9: A response with `rsp_err` high ends the load. It pulses `fault_valid` with `fault_kind` = 3 and `fault_addr` equal to that byte's address, and no register write follows.
- R10: `busy` rises the cycle after a load is accepted and falls with the write or the fault. An `instr_valid` seen while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| vl_bits | input | $clog2(VLEN_MAX)+1 | Current vector length in bits |
| align_en | input | 1 | Enforce 16-byte base alignment |
| sp_chk_en | input | 1 | Check stack pointer alignment when it is the base |
| rf_rd_idx | output | 5 | Scalar register read index |
| rf_rd_data | input | XLEN | Scalar register read data (same cycle) |
| sp_value | input | XLEN | Stack pointer value |
| busy | output | 1 | Load in progress |
| undef | output | 1 | Undefined-instruction pulse |
| cfg_err | output | 1 | Illegal vector length pulse |
| fault_valid | output | 1 | Fault pulse |
| fault_kind | output | 2 | 1 stack pointer, 2 alignment, 3 memory error |
| fault_addr | output | XLEN | Address tied to the fault |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | XLEN | Byte read address |
| mem_ready | input | 1 | Request accepted |
| rsp_valid | input | 1 | Response byte present |
| rsp_data | input | 8 | Response byte |
| rsp_err | input | 1 | Response carries an error |
| vrf_we | output | 1 | Vector register write strobe |
| vrf_idx | output | 5 | Destination vector register |
| vrf_data | output | VLEN_MAX | Assembled vector value |

## Verification
The `undef`, `cfg_err` and both alignment faults are registered at the accepting edge. The bench samples them at the falling edge that follows and checks at the next falling edge that they have gone. Each byte request is compared with the bench's queue of expected addresses at the edge where `mem_ready` completes it. The register write or memory fault appears at the falling edge where `busy` is first seen low, one edge after the final response, and is checked there. Memory latency and a toggling ready pattern vary the spacing between these events without moving any result relative to its triggering edge.

// File: rtl/vload_pkg.sv
package vload_pkg;
    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_SP    = 2'd1,
        FK_ALIGN = 2'd2,
        FK_MEM   = 2'd3
    } fault_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    localparam logic [9:0] OPC_HI  = 10'b1000010110;
    localparam logic [2:0] OPC_MID = 3'b010;
endpackage

// File: rtl/vload_decode.sv
module vload_decode #(
    parameter int VLEN_MAX = 2048,
    localparam int VL_W  = $clog2(VLEN_MAX) + 1,
    localparam int VLB_W = VL_W - 3
) (
    input  logic [31:0]       word,
    input  logic [VL_W-1:0]   vl_bits,
    output logic              opc_ok,
    output logic              vl_ok,
    output logic signed [8:0] imm,
    output logic [4:0]        rn,
    output logic [4:0]        rt,
    output logic [VLB_W-1:0]  vlb
);
    import vload_pkg::*;

    always_comb begin
        opc_ok = (word[31:22] == OPC_HI) && (word[15:13] == OPC_MID);
        imm    = $signed({word[21:16], word[12:10]});
        rn     = word[9:5];
        rt     = word[4:0];
        vl_ok  = (vl_bits != '0) && (vl_bits[6:0] == 7'd0)
                 && (int'(vl_bits) <= VLEN_MAX);
        vlb    = vl_bits[VL_W-1:3];
    end
endmodule

// File: rtl/vload_agen.sv
module vload_agen #(
    parameter int XLEN  = 64,
    parameter int VLB_W = 9,
    localparam int OFF_W = 9 + VLB_W + 1
) (
    input  logic [XLEN-1:0]   base,
    input  logic signed [8:0] imm,
    input  logic [VLB_W-1:0]  vlb,
    output logic [XLEN-1:0]   ea,
    output logic              base_misaligned
);
    logic signed [OFF_W-1:0] off;

    always_comb begin
        off             = OFF_W'(imm) * $signed({{(OFF_W-VLB_W){1'b0}}, vlb});
        ea              = base + {{(XLEN-OFF_W){off[OFF_W-1]}}, off};
        base_misaligned = (base[3:0] != 4'd0);
    end
endmodule

// File: rtl/vload_seq.sv
module vload_seq #(
    parameter int VLEN_MAX = 2048,
    parameter int XLEN     = 64,
    localparam int VL_W  = $clog2(VLEN_MAX) + 1,
    localparam int VLB_W = VL_W - 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                instr_valid,
    input  logic [31:0]         instr_word,
    input  logic [VL_W-1:0]     vl_bits,
    input  logic                align_en,
    input  logic                sp_chk_en,
    output logic [4:0]          rf_rd_idx,
    input  logic [XLEN-1:0]     rf_rd_data,
    input  logic [XLEN-1:0]     sp_value,
    output logic                busy,
    output logic                undef,
    output logic                cfg_err,
    output logic                fault_valid,
    output logic [1:0]          fault_kind,
    output logic [XLEN-1:0]     fault_addr,
    output logic                mem_req,
    output logic [XLEN-1:0]     mem_addr,
    input  logic                mem_ready,
    input  logic                rsp_valid,
    input  logic [7:0]          rsp_data,
    input  logic                rsp_err,
    output logic                vrf_we,
    output logic [4:0]          vrf_idx,
    output logic [VLEN_MAX-1:0] vrf_data
);
    import vload_pkg::*;

    typedef struct packed {
        seq_state_e         st;
        logic [XLEN-1:0]    addr;
        logic [VLB_W-1:0]   cnt;
        logic [VLB_W-1:0]   last;
        logic [4:0]         rt;
        logic [VLEN_MAX-1:0] data;
        logic               undef;
        logic               cfg;
        logic               fv;
        fault_kind_e        fk;
        logic [XLEN-1:0]    faddr;
        logic               we;
    } seq_t;

    seq_t s_d, s_q;

    logic              opc_ok, vl_ok, misal;
    logic signed [8:0] imm;
    logic [4:0]        rn, rt;
    logic [VLB_W-1:0]  vlb;
    logic [XLEN-1:0]   base, ea;

    vload_decode #(.VLEN_MAX(VLEN_MAX)) u_dec (
        .word    (instr_word),
        .vl_bits (vl_bits),
        .opc_ok  (opc_ok),
        .vl_ok   (vl_ok),
        .imm     (imm),
        .rn      (rn),
        .rt      (rt),
        .vlb     (vlb)
    );

    assign rf_rd_idx = rn;
    assign base      = (rn == 5'd31) ? sp_value : rf_rd_data;

    vload_agen #(.XLEN(XLEN), .VLB_W(VLB_W)) u_agen (
        .base            (base),
        .imm             (imm),
        .vlb             (vlb),
        .ea              (ea),
        .base_misaligned (misal)
    );

    always_comb begin
        s_d       = s_q;
        s_d.undef = 1'b0;
        s_d.cfg   = 1'b0;
        s_d.fv    = 1'b0;
        s_d.we    = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (!opc_ok) begin
                        s_d.undef = 1'b1;
                    end else if (!vl_ok) begin
                        s_d.cfg = 1'b1;
                    end else if (rn == 5'd31 && sp_chk_en && sp_value[3:0] != 4'd0) begin
                        s_d.fv    = 1'b1;
                        s_d.fk    = FK_SP;
                        s_d.faddr = sp_value;
                    end else if (align_en && misal) begin
                        s_d.fv    = 1'b1;
                        s_d.fk    = FK_ALIGN;
                        s_d.faddr = ea;
                    end else begin
                        s_d.st   = ST_REQ;
                        s_d.addr = ea;
                        s_d.cnt  = '0;
                        s_d.last = vlb - 1'b1;
                        s_d.rt   = rt;
                        s_d.data = '0;
                    end
                end
            end
            ST_REQ: begin
                if (mem_ready) s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        s_d.st    = ST_IDLE;
                        s_d.fv    = 1'b1;
                        s_d.fk    = FK_MEM;
                        s_d.faddr = s_q.addr;
                    end else begin
                        s_d.data[{s_q.cnt, 3'b000} +: 8] = rsp_data;
                        if (s_q.cnt == s_q.last) begin
                            s_d.st = ST_IDLE;
                            s_d.we = 1'b1;
                        end else begin
                            s_d.cnt  = s_q.cnt + 1'b1;
                            s_d.addr = s_q.addr + 1'b1;
                            s_d.st   = ST_REQ;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, fk: FK_NONE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy        = (s_q.st != ST_IDLE);
    assign undef       = s_q.undef;
    assign cfg_err     = s_q.cfg;
    assign fault_valid = s_q.fv;
    assign fault_kind  = s_q.fk;
    assign fault_addr  = s_q.faddr;
    assign mem_req     = (s_q.st == ST_REQ);
    assign mem_addr    = s_q.addr;
    assign vrf_we      = s_q.we;
    assign vrf_idx     = s_q.rt;
    assign vrf_data    = s_q.data;

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!busy && !mem_req && !vrf_we)); // R1
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !mem_req && !vrf_we)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R7
    AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        vrf_we |-> (!busy && !fault_valid)); // R8
    AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (!busy && !vrf_we)); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({undef, cfg_err, fault_valid, vrf_we})); // R10
endmodule

// File: tb/vload_seq_test.sv
module vload_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int VMAX = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic [11:0] vl_bits = 12'd128;
    logic        align_en = 1'b0;
    logic        sp_chk_en = 1'b0;
    logic [4:0]  rf_rd_idx;
    logic [63:0] rf_rd_data;
    logic [63:0] sp_value = '0;
    logic        busy, undef, cfg_err, fault_valid;
    logic [1:0]  fault_kind;
    logic [63:0] fault_addr;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = '0;
    logic        rsp_err = 1'b0;
    logic        vrf_we;
    logic [4:0]  vrf_idx;
    logic [VMAX-1:0] vrf_data;

    logic [63:0] regs [32];
    assign rf_rd_data = regs[rf_rd_idx];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit err_en = 1'b0;
    logic [63:0] err_addr = '0;
    int lat_cfg = 0;
    int ready_mode = 0;
    logic [63:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vload_seq uut (.*);

    function automatic logic [7:0] memfn(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] mk(input logic [8:0] imm9, input logic [4:0] n, input logic [4:0] t);
        return {10'b1000010110, imm9[8:3], 3'b010, imm9[2:0], n, t};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder and per-cycle request monitor (R7)
    initial begin
        bit hs;
        logic [63:0] ha;
        bit pend = 1'b0;
        logic [63:0] paddr = '0;
        int plat = 0;
        int cyc = 0;
        forever begin
            @(posedge clk);
            hs = mem_req && mem_ready;
            ha = mem_addr;
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            rsp_err   = 1'b0;
            if (pend) begin
                if (plat == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = memfn(paddr);
                    rsp_err   = err_en && (paddr == err_addr);
                    pend      = 1'b0;
                end else begin
                    plat--;
                end
            end
            if (hs) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected request", ha, 64'd0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk(ha == e, "R7 request address", ha, e);
                end
                pend  = 1'b1;
                paddr = ha;
                plat  = lat_cfg;
            end
            mem_ready = (ready_mode == 0) ? 1'b1 : cyc[0];
        end
    end

    task automatic run_load(input logic [31:0] w, input int vl, input bit aen,
                            input bit spchk, input bit inject, input string tag);
        bit opc, vlok;
        int imm, vlb, n, t, kind, cyc;
        logic [63:0] base, ea;
        logic [VMAX-1:0] ev;
        opc  = (w[31:22] == 10'b1000010110) && (w[15:13] == 3'b010);
        vlok = (vl > 0) && (vl % 128 == 0) && (vl <= VMAX);
        n    = int'(w[9:5]);
        t    = int'(w[4:0]);
        imm  = int'($signed({w[21:16], w[12:10]}));
        vlb  = vl / 8;
        base = (n == 31) ? sp_value : regs[n];
        ea   = base + 64'(longint'(imm) * longint'(vlb));
        if (!opc) kind = 1;
        else if (!vlok) kind = 2;
        else if (n == 31 && spchk && sp_value[3:0] != 0) kind = 3;
        else if (aen && base[3:0] != 0) kind = 4;
        else kind = 0;
        ev = '0;
        if (kind == 0) begin
            for (int e = 0; e < vlb; e++) begin
                exp_q.push_back(ea + 64'(e));
                ev[e*8 +: 8] = memfn(ea + 64'(e));
                if (err_en && (ea + 64'(e)) == err_addr) break;
            end
        end
        @(negedge clk);
        instr_word  = w;
        vl_bits     = 12'(vl);
        align_en    = aen;
        sp_chk_en   = spchk;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        case (kind)
            1: begin
                chk(undef == 1'b1, {"R1 undef pulse ", tag}, 64'(undef), 64'd1);
                chk(busy == 1'b0, {"R1 busy stays low ", tag}, 64'(busy), 64'd0);
            end
            2: begin
                chk(cfg_err == 1'b1, {"R2 cfg_err pulse ", tag}, 64'(cfg_err), 64'd1);
                chk(busy == 1'b0, {"R2 busy stays low ", tag}, 64'(busy), 64'd0);
            end
            3: begin
                chk(fault_valid && fault_kind == 2'd1, {"R5 sp fault ", tag}, {62'd0, fault_kind}, 64'd1);
                chk(fault_addr == sp_value, {"R5 sp fault addr ", tag}, fault_addr, sp_value);
            end
            4: begin
                chk(fault_valid && fault_kind == 2'd2, {"R6 align fault ", tag}, {62'd0, fault_kind}, 64'd2);
                chk(fault_addr == ea, {"R6 align fault addr ", tag}, fault_addr, ea);
            end
            default: chk(busy == 1'b1, {"R10 busy after accept ", tag}, 64'(busy), 64'd1);
        endcase
        if (kind != 0) begin
            @(negedge clk);
            chk(!undef && !cfg_err && !fault_valid, {"R1 pulse is one cycle ", tag},
                {61'd0, undef, cfg_err, fault_valid}, 64'd0);
            chk(!mem_req && !busy && !vrf_we, {"R1 no activity ", tag},
                {61'd0, mem_req, busy, vrf_we}, 64'd0);
            return;
        end
        cyc = 0;
        while (busy) begin
            if (inject && cyc == 3) begin
                instr_word  = mk(9'd0, 5'd3, 5'd0);
                vl_bits     = 12'd128;
                instr_valid = 1'b1;
            end
            if (inject && cyc == 4) instr_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        if (err_en && exp_q.size() == 0) begin
            chk(fault_valid && fault_kind == 2'd3, {"R9 mem fault ", tag}, {62'd0, fault_kind}, 64'd3);
            chk(fault_addr == err_addr, {"R9 mem fault addr ", tag}, fault_addr, err_addr);
            chk(vrf_we == 1'b0, {"R9 no write ", tag}, 64'(vrf_we), 64'd0);
        end else begin
            chk(vrf_we == 1'b1, {"R8 write strobe ", tag}, 64'(vrf_we), 64'd1);
            chk(vrf_idx == 5'(t), {"R8 write index ", tag}, 64'(vrf_idx), 64'(t));
            checks++;
            if (vrf_data != ev) begin
                failures++;
                $display("FAIL R8 data %s actual=%h expected=%h", tag, vrf_data, ev);
            end
        end
        chk(exp_q.size() == 0, {"R7 request count ", tag}, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
        @(negedge clk);
        chk(!vrf_we && !fault_valid && !busy, {"R10 quiet after end ", tag},
            {61'd0, vrf_we, fault_valid, busy}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 64'h4000_0000 + 64'(i) * 64'h100;
        regs[3] = 64'h1000;
        regs[4] = 64'h2000;
        regs[5] = 64'h3004;
        regs[6] = 64'h0;
        regs[7] = 64'h10;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !vrf_we && !undef && !fault_valid, "R10 reset state",
            {59'd0, busy, mem_req, vrf_we, undef, fault_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_load(mk(9'd0, 5'd3, 5'd1) ^ 32'h8000_0000, 128, 1'b0, 1'b0, 1'b0, "R1 top bits");
        run_load(mk(9'd0, 5'd3, 5'd1) ^ 32'h0000_2000, 128, 1'b0, 1'b0, 1'b0, "R1 mid bits");
        run_load(mk(9'd0, 5'd3, 5'd1), 100,  1'b0, 1'b0, 1'b0, "R2 vl100");
        run_load(mk(9'd0, 5'd3, 5'd1), 0,    1'b0, 1'b0, 1'b0, "R2 vl0");
        run_load(mk(9'd0, 5'd3, 5'd1), 2176, 1'b0, 1'b0, 1'b0, "R2 vl2176");

        run_load(mk(9'd0, 5'd3, 5'd1), 128, 1'b1, 1'b0, 1'b0, "R3 imm0 vl128");
        lat_cfg = 2; ready_mode = 1;
        run_load(mk(9'h1FF, 5'd4, 5'd2), 256, 1'b1, 1'b0, 1'b1, "R3 R10 imm-1 inject");
        lat_cfg = 0; ready_mode = 0;
        run_load(mk(9'h100, 5'd6, 5'd31), 128, 1'b1, 1'b0, 1'b0, "R3 wrap imm-256");
        run_load(mk(9'h0FF, 5'd7, 5'd7), 2048, 1'b0, 1'b0, 1'b0, "R3 imm255 vl2048");

        sp_value = 64'h8000;
        run_load(mk(9'd2, 5'd31, 5'd9), 384, 1'b1, 1'b1, 1'b0, "R4 sp base");
        sp_value = 64'h8008;
        run_load(mk(9'd2, 5'd31, 5'd9), 384, 1'b0, 1'b1, 1'b0, "R5 sp misaligned");
        run_load(mk(9'd1, 5'd31, 5'd10), 128, 1'b0, 1'b0, 1'b0, "R4 R6 unchecked sp");
        run_load(mk(9'd3, 5'd5, 5'd11), 128, 1'b1, 1'b0, 1'b0, "R6 enforced");
        run_load(mk(9'd3, 5'd5, 5'd11), 128, 1'b0, 1'b0, 1'b0, "R6 not enforced");

        err_en = 1'b1; err_addr = 64'h1005; lat_cfg = 1;
        run_load(mk(9'd0, 5'd3, 5'd12), 512, 1'b1, 1'b0, 1'b0, "R9 error byte5");
        err_en = 1'b0; lat_cfg = 0;
        run_load(mk(9'd1, 5'd3, 5'd13), 128, 1'b1, 1'b0, 1'b0, "R8 after fault");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule